// File: doc/BRIEF.md
# Tiled Matrix-Multiply Stage Command Sequencer

This block drives one processing element through a tiled matrix multiply C = A x B. It does not move data or compute anything itself. It turns one start request into the ordered stream of stage commands that other units execute. The request carries the three matrix dimensions, the three tile sizes, the byte addresses of A, B and C, the element width in bytes, and two flags. Each flag says that one input operand already sits in local memory. The block walks every output tile and, inside it, every tile along the shared dimension. For each step it issues commands for DMA reads from external memory, a fetch into the register file, the multiply-accumulate, a store back to local memory and a DMA write to external memory.

Two rules keep the traffic down. A DMA read is left out for an operand whose resident flag is set. The accumulator stays in the register file for the whole inner loop, so the store and the write-back of an output tile are issued only once, after its last inner tile. Commands leave one at a time over a valid/ready handshake. A done pulse marks the end of the job.

Top module: `gemm_stage_seq`

## Requirements
- R1: The tile count along each dimension is ceil(dimension / tile size). A dimension of zero gives one tile. A tile size of zero is treated as one.
- R2: Tiles are visited with the row-tile index m outermost, the column-tile index n next, and the inner-tile index k innermost.
- R3: Within one inner step the commands run in this order: read A, read B, fetch, multiply-accumulate, store, write-back. Commands that do not apply to that step are left out.
- R4: The read of A is left out when `pin_a_i` was set at start. The read of B is left out when `pin_b_i` was set at start.
- R5: Store and write-back are issued only in the last inner step (k = Kt-1) of each (m,n) output tile.
- R6: `cmd_kind_o` encodes the command as 1 read, 2 fetch, 3 multiply-accumulate, 4 store and 5 write-back. `cmd_tag_o` is 1 for A, 2 for B, 3 for C, and 0 for fetch and multiply-accumulate. The byte counts and tile dimensions, with ta = tm·tk·eb, tb = tk·tn·eb and tc = tm·tn·eb, are:
  - read A: ta bytes, dimensions (tm, tk).
  - read B: tb bytes, dimensions (tk, tn).
  - fetch: ta+tb bytes, dimensions (tm, tn).
  - multiply-accumulate: 0 bytes, dimensions (tm, tn).
  - store and write-back: tc bytes each, dimensions (tm, tn).
- R7: The A address is baseA + (m·Kt+k)·ta. The B address is baseB + (k·Nt+n)·tb. The C address of store and write-back is baseC + (m·Nt+n)·tc. Fetch and multiply-accumulate carry address 0. All addresses are taken modulo 2^ADDR_W.
- R8: A command stays valid with unchanged fields until `cmd_ready_i` is high. The sequencer moves on exactly one command per accepted transfer.
- R9: `done_o` is high for exactly one cycle, in the cycle after the final write-back is accepted. `busy_o` is low in that cycle.
- R10: A start request that arrives while `busy_o` is high has no effect on the command stream.
- R11: `cmd_first_o` is 1 on the multiply-accumulate command of k = 0 and 0 on every other command.
- R12: After reset `busy_o`, `cmd_valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| dim_m_i | input | DIM_W | Rows of A and C |
| dim_n_i | input | DIM_W | Columns of B and C |
| dim_k_i | input | DIM_W | Shared dimension |
| tile_m_i | input | DIM_W | Tile rows |
| tile_n_i | input | DIM_W | Tile columns |
| tile_k_i | input | DIM_W | Tile depth |
| base_a_i | input | ADDR_W | A base address |
| base_b_i | input | ADDR_W | B base address |
| base_c_i | input | ADDR_W | C base address |
| elem_bytes_i | input | EB_W | Bytes per element |
| pin_a_i | input | 1 | A already resident locally |
| pin_b_i | input | 1 | B already resident locally |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Command accepted by the consumer |
| cmd_kind_o | output | 3 | Command kind (R6) |
| cmd_addr_o | output | ADDR_W | Command address |
| cmd_bytes_o | output | 2*DIM_W+EB_W+1 | Command byte count |
| cmd_tag_o | output | 2 | Operand tag (R6) |
| cmd_dim0_o | output | DIM_W | First tile dimension |
| cmd_dim1_o | output | DIM_W | Second tile dimension |
| cmd_first_o | output | 1 | Clear-accumulator flag on multiply-accumulate |

## Verification
A wrong stage register shows at once on the next presented command: the kind, tag or byte count no longer matches the expected stream. A wrong tile index shows as a bad address no later than the following read or write-back. A lost or extra step shifts every later command, so a cycle-by-cycle comparison against an ordered expected list catches it at the first command after the fault. Hold behaviour under stalled ready is compared on every stalled cycle. The command count is checked against the expected tile walk at the end of each job.

// File: rtl/gemm_seq_pkg.sv
package gemm_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RD_A  = 3'd1,
      ST_RD_B  = 3'd2,
      ST_FETCH = 3'd3,
      ST_MAC   = 3'd4,
      ST_STORE = 3'd5,
      ST_WRITE = 3'd6
   } stage_e;

   localparam logic [2:0] KIND_NONE  = 3'd0;
   localparam logic [2:0] KIND_RD    = 3'd1;
   localparam logic [2:0] KIND_FETCH = 3'd2;
   localparam logic [2:0] KIND_MAC   = 3'd3;
   localparam logic [2:0] KIND_STORE = 3'd4;
   localparam logic [2:0] KIND_WR    = 3'd5;

   localparam logic [1:0] TAG_NONE = 2'd0;
   localparam logic [1:0] TAG_A    = 2'd1;
   localparam logic [1:0] TAG_B    = 2'd2;
   localparam logic [1:0] TAG_C    = 2'd3;

   localparam int NUM_AXES = 3;

   // entry stage of an inner step, given which operands are resident
   function automatic stage_e entry_stage(input logic res_a, input logic res_b);
      if (!res_a)      return ST_RD_A;
      else if (!res_b) return ST_RD_B;
      else             return ST_FETCH;
   endfunction

endpackage

// File: rtl/gemm_tile_count.sv
module gemm_tile_count #(
   parameter int DIM_W = 12
) (
   input  logic [DIM_W-1:0] dim_i,
   input  logic [DIM_W-1:0] tile_i,
   output logic [DIM_W-1:0] cnt_o
);
   localparam int EXT_W = DIM_W + 1;

   logic [EXT_W-1:0] tile_eff;
   logic [EXT_W-1:0] rounded;

   always_comb begin
      tile_eff = (tile_i == '0) ? EXT_W'(1) : {1'b0, tile_i};
      rounded  = {1'b0, dim_i} + tile_eff - EXT_W'(1);
      if (dim_i == '0) cnt_o = DIM_W'(1);
      else             cnt_o = DIM_W'(rounded / tile_eff);
   end

   // R1: a tile count is never zero
   always_comb begin
      assert_cnt_nonzero_R1: assert (cnt_o != '0 || $isunknown(dim_i) || $isunknown(tile_i));
   end

endmodule

// File: rtl/gemm_tile_walker.sv
module gemm_tile_walker
   import gemm_seq_pkg::*;
#(
   parameter int DIM_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             step_i,
   input  logic [DIM_W-1:0] cnt_m_i,
   input  logic [DIM_W-1:0] cnt_n_i,
   input  logic [DIM_W-1:0] cnt_k_i,
   output logic [DIM_W-1:0] m_o,
   output logic [DIM_W-1:0] n_o,
   output logic [DIM_W-1:0] k_o,
   output logic             last_k_o,
   output logic             last_tile_o
);
   // axis 0 is innermost (k), axis 2 is outermost (m)
   logic [DIM_W-1:0] lim   [NUM_AXES];
   logic [DIM_W-1:0] idx_q [NUM_AXES];
   logic             wrap  [NUM_AXES];
   logic             adv   [NUM_AXES+1];

   assign lim[0] = cnt_k_i;
   assign lim[1] = cnt_n_i;
   assign lim[2] = cnt_m_i;
   assign adv[0] = step_i;

   for (genvar ax = 0; ax < NUM_AXES; ax++) begin : g_axis
      assign wrap[ax]   = (idx_q[ax] == lim[ax] - DIM_W'(1));
      assign adv[ax+1]  = adv[ax] & wrap[ax];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       idx_q[ax] <= '0;
         else if (clear_i) idx_q[ax] <= '0;
         else if (adv[ax]) idx_q[ax] <= wrap[ax] ? '0 : idx_q[ax] + DIM_W'(1);
      end
   end

   assign k_o         = idx_q[0];
   assign n_o         = idx_q[1];
   assign m_o         = idx_q[2];
   assign last_k_o    = wrap[0];
   assign last_tile_o = wrap[0] & wrap[1] & wrap[2];

   // R2: the inner index stays inside the inner tile count
   assert_k_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> (k_o < cnt_k_i));

   // R2: the outer index moves only when both inner indices wrap
   assert_m_moves_on_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && step_i && !(wrap[0] && wrap[1])) |=> $stable(m_o));

endmodule

// File: rtl/gemm_cmd_fmt.sv
module gemm_cmd_fmt
   import gemm_seq_pkg::*;
#(
   parameter int DIM_W   = 12,
   parameter int ADDR_W  = 32,
   parameter int EB_W    = 4,
   parameter int BYTES_W = 2*DIM_W + EB_W + 1
) (
   input  stage_e            stage_i,
   input  logic [DIM_W-1:0]  m_i,
   input  logic [DIM_W-1:0]  n_i,
   input  logic [DIM_W-1:0]  k_i,
   input  logic [DIM_W-1:0]  cnt_n_i,
   input  logic [DIM_W-1:0]  cnt_k_i,
   input  logic [DIM_W-1:0]  tm_i,
   input  logic [DIM_W-1:0]  tn_i,
   input  logic [DIM_W-1:0]  tk_i,
   input  logic [EB_W-1:0]   eb_i,
   input  logic [ADDR_W-1:0] base_a_i,
   input  logic [ADDR_W-1:0] base_b_i,
   input  logic [ADDR_W-1:0] base_c_i,
   output logic [2:0]        kind_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BYTES_W-1:0] bytes_o,
   output logic [1:0]        tag_o,
   output logic [DIM_W-1:0]  dim0_o,
   output logic [DIM_W-1:0]  dim1_o,
   output logic              first_o
);
   logic [BYTES_W-1:0] sz_a, sz_b, sz_c;
   logic [ADDR_W-1:0]  idx_a, idx_b, idx_c;
   logic [ADDR_W-1:0]  addr_a, addr_b, addr_c;

   always_comb begin
      sz_a   = BYTES_W'(tm_i) * BYTES_W'(tk_i) * BYTES_W'(eb_i);
      sz_b   = BYTES_W'(tk_i) * BYTES_W'(tn_i) * BYTES_W'(eb_i);
      sz_c   = BYTES_W'(tm_i) * BYTES_W'(tn_i) * BYTES_W'(eb_i);
      idx_a  = ADDR_W'(m_i) * ADDR_W'(cnt_k_i) + ADDR_W'(k_i);
      idx_b  = ADDR_W'(k_i) * ADDR_W'(cnt_n_i) + ADDR_W'(n_i);
      idx_c  = ADDR_W'(m_i) * ADDR_W'(cnt_n_i) + ADDR_W'(n_i);
      addr_a = base_a_i + idx_a * ADDR_W'(sz_a);
      addr_b = base_b_i + idx_b * ADDR_W'(sz_b);
      addr_c = base_c_i + idx_c * ADDR_W'(sz_c);
   end

   always_comb begin
      kind_o  = KIND_NONE;
      addr_o  = '0;
      bytes_o = '0;
      tag_o   = TAG_NONE;
      dim0_o  = tm_i;
      dim1_o  = tn_i;
      first_o = 1'b0;
      case (stage_i)
         ST_RD_A: begin
            kind_o  = KIND_RD;
            addr_o  = addr_a;
            bytes_o = sz_a;
            tag_o   = TAG_A;
            dim1_o  = tk_i;
         end
         ST_RD_B: begin
            kind_o  = KIND_RD;
            addr_o  = addr_b;
            bytes_o = sz_b;
            tag_o   = TAG_B;
            dim0_o  = tk_i;
         end
         ST_FETCH: begin
            kind_o  = KIND_FETCH;
            bytes_o = sz_a + sz_b;
         end
         ST_MAC: begin
            kind_o  = KIND_MAC;
            first_o = (k_i == '0);
         end
         ST_STORE: begin
            kind_o  = KIND_STORE;
            addr_o  = addr_c;
            bytes_o = sz_c;
            tag_o   = TAG_C;
         end
         ST_WRITE: begin
            kind_o  = KIND_WR;
            addr_o  = addr_c;
            bytes_o = sz_c;
            tag_o   = TAG_C;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/gemm_stage_seq.sv
module gemm_stage_seq
   import gemm_seq_pkg::*;
#(
   parameter  int DIM_W   = 12,
   parameter  int ADDR_W  = 32,
   parameter  int EB_W    = 4,
   localparam int BYTES_W = 2*DIM_W + EB_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [DIM_W-1:0]   dim_m_i,
   input  logic [DIM_W-1:0]   dim_n_i,
   input  logic [DIM_W-1:0]   dim_k_i,
   input  logic [DIM_W-1:0]   tile_m_i,
   input  logic [DIM_W-1:0]   tile_n_i,
   input  logic [DIM_W-1:0]   tile_k_i,
   input  logic [ADDR_W-1:0]  base_a_i,
   input  logic [ADDR_W-1:0]  base_b_i,
   input  logic [ADDR_W-1:0]  base_c_i,
   input  logic [EB_W-1:0]    elem_bytes_i,
   input  logic               pin_a_i,
   input  logic               pin_b_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               cmd_valid_o,
   input  logic               cmd_ready_i,
   output logic [2:0]         cmd_kind_o,
   output logic [ADDR_W-1:0]  cmd_addr_o,
   output logic [BYTES_W-1:0] cmd_bytes_o,
   output logic [1:0]         cmd_tag_o,
   output logic [DIM_W-1:0]   cmd_dim0_o,
   output logic [DIM_W-1:0]   cmd_dim1_o,
   output logic               cmd_first_o
);
   initial begin
      param_check: assert (DIM_W >= 2 && ADDR_W >= 8 && EB_W >= 1)
         else $error("gemm_stage_seq: parameter out of range");
   end

   stage_e stage_q, stage_d;
   logic   done_q;

   logic [DIM_W-1:0]  dim_q  [NUM_AXES];
   logic [DIM_W-1:0]  tile_q [NUM_AXES];
   logic [DIM_W-1:0]  cnt    [NUM_AXES];
   logic [DIM_W-1:0]  dim_in [NUM_AXES];
   logic [DIM_W-1:0]  tile_in[NUM_AXES];
   logic [ADDR_W-1:0] base_a_q, base_b_q, base_c_q;
   logic [EB_W-1:0]   eb_q;
   logic              pin_a_q, pin_b_q;

   logic             launch, accept, step;
   logic [DIM_W-1:0] m_idx, n_idx, k_idx;
   logic             last_k, last_tile;

   assign launch = start_i && (stage_q == ST_IDLE);
   assign accept = cmd_valid_o && cmd_ready_i;
   assign step   = accept && ((stage_q == ST_MAC && !last_k) || stage_q == ST_WRITE);

   // axis order in the arrays: 0 = m, 1 = n, 2 = k
   assign dim_in[0]  = dim_m_i;
   assign dim_in[1]  = dim_n_i;
   assign dim_in[2]  = dim_k_i;
   assign tile_in[0] = tile_m_i;
   assign tile_in[1] = tile_n_i;
   assign tile_in[2] = tile_k_i;

   for (genvar ax = 0; ax < NUM_AXES; ax++) begin : g_axis
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dim_q[ax]  <= '0;
            tile_q[ax] <= DIM_W'(1);
         end else if (launch) begin
            dim_q[ax]  <= dim_in[ax];
            tile_q[ax] <= tile_in[ax];
         end
      end

      gemm_tile_count #(.DIM_W(DIM_W)) u_cnt (
         .dim_i  (dim_q[ax]),
         .tile_i (tile_q[ax]),
         .cnt_o  (cnt[ax])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_a_q <= '0;
         base_b_q <= '0;
         base_c_q <= '0;
         eb_q     <= '0;
         pin_a_q  <= 1'b0;
         pin_b_q  <= 1'b0;
      end else if (launch) begin
         base_a_q <= base_a_i;
         base_b_q <= base_b_i;
         base_c_q <= base_c_i;
         eb_q     <= elem_bytes_i;
         pin_a_q  <= pin_a_i;
         pin_b_q  <= pin_b_i;
      end
   end

   gemm_tile_walker #(.DIM_W(DIM_W)) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (launch),
      .step_i      (step),
      .cnt_m_i     (cnt[0]),
      .cnt_n_i     (cnt[1]),
      .cnt_k_i     (cnt[2]),
      .m_o         (m_idx),
      .n_o         (n_idx),
      .k_o         (k_idx),
      .last_k_o    (last_k),
      .last_tile_o (last_tile)
   );

   always_comb begin
      stage_d = stage_q;
      if (stage_q == ST_IDLE) begin
         if (launch) stage_d = entry_stage(pin_a_i, pin_b_i);
      end else if (accept) begin
         case (stage_q)
            ST_RD_A:  stage_d = pin_b_q ? ST_FETCH : ST_RD_B;
            ST_RD_B:  stage_d = ST_FETCH;
            ST_FETCH: stage_d = ST_MAC;
            ST_MAC:   stage_d = last_k ? ST_STORE : entry_stage(pin_a_q, pin_b_q);
            ST_STORE: stage_d = ST_WRITE;
            ST_WRITE: stage_d = last_tile ? ST_IDLE : entry_stage(pin_a_q, pin_b_q);
            default:  stage_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         stage_q <= stage_d;
         done_q  <= accept && (stage_q == ST_WRITE) && last_tile;
      end
   end

   assign busy_o      = (stage_q != ST_IDLE);
   assign cmd_valid_o = busy_o;
   assign done_o      = done_q;

   gemm_cmd_fmt #(
      .DIM_W   (DIM_W),
      .ADDR_W  (ADDR_W),
      .EB_W    (EB_W),
      .BYTES_W (BYTES_W)
   ) u_fmt (
      .stage_i  (stage_q),
      .m_i      (m_idx),
      .n_i      (n_idx),
      .k_i      (k_idx),
      .cnt_n_i  (cnt[1]),
      .cnt_k_i  (cnt[2]),
      .tm_i     (tile_q[0]),
      .tn_i     (tile_q[1]),
      .tk_i     (tile_q[2]),
      .eb_i     (eb_q),
      .base_a_i (base_a_q),
      .base_b_i (base_b_q),
      .base_c_i (base_c_q),
      .kind_o   (cmd_kind_o),
      .addr_o   (cmd_addr_o),
      .bytes_o  (cmd_bytes_o),
      .tag_o    (cmd_tag_o),
      .dim0_o   (cmd_dim0_o),
      .dim1_o   (cmd_dim1_o),
      .first_o  (cmd_first_o)
   );

   // R8: a stalled command holds its content
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_kind_o)
         && $stable(cmd_addr_o) && $stable(cmd_bytes_o) && $stable(cmd_tag_o)));

   // R5: output-side traffic only in the last inner step
   assert_out_last_k_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && (cmd_kind_o == KIND_STORE || cmd_kind_o == KIND_WR)) |-> last_k);

   // R4: no read of a resident operand
   assert_skip_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && cmd_kind_o == KIND_RD && cmd_tag_o == TAG_A) |-> !pin_a_q);
   assert_skip_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && cmd_kind_o == KIND_RD && cmd_tag_o == TAG_B) |-> !pin_b_q);

   // R9: done is a single pulse following an accepted write-back
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_done_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(accept && cmd_kind_o == KIND_WR) && !busy_o);

   // R10: a start while busy leaves the job description untouched
   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> ($stable(base_a_q) && $stable(base_c_q)
         && $stable(pin_a_q) && $stable(pin_b_q) && $stable(eb_q)));

   // R11: the clear flag appears only on multiply-accumulate commands
   assert_first_on_mac_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && cmd_first_o) |-> (cmd_kind_o == KIND_MAC));

endmodule

// File: tb/gemm_stage_seq_tb.sv
`timescale 1ns/1ps
module gemm_stage_seq_tb;
   localparam int DIM_W   = 12;
   localparam int ADDR_W  = 32;
   localparam int EB_W    = 4;
   localparam int BYTES_W = 2*DIM_W + EB_W + 1;

   typedef struct packed {
      logic [2:0]         kind;
      logic [ADDR_W-1:0]  addr;
      logic [BYTES_W-1:0] bytes;
      logic [1:0]         tag;
      logic [DIM_W-1:0]   d0;
      logic [DIM_W-1:0]   d1;
      logic               first;
   } cmd_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [DIM_W-1:0] dim_m_i = '0, dim_n_i = '0, dim_k_i = '0;
   logic [DIM_W-1:0] tile_m_i = '0, tile_n_i = '0, tile_k_i = '0;
   logic [ADDR_W-1:0] base_a_i = '0, base_b_i = '0, base_c_i = '0;
   logic [EB_W-1:0] elem_bytes_i = '0;
   logic pin_a_i = 1'b0, pin_b_i = 1'b0;
   logic cmd_ready_i = 1'b0;
   logic busy_o, done_o, cmd_valid_o, cmd_first_o;
   logic [2:0] cmd_kind_o;
   logic [ADDR_W-1:0] cmd_addr_o;
   logic [BYTES_W-1:0] cmd_bytes_o;
   logic [1:0] cmd_tag_o;
   logic [DIM_W-1:0] cmd_dim0_o, cmd_dim1_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [7:0] lfsr = 8'hA5;
   cmd_t exp_q[$];

   always #2.5 clk = ~clk;

   gemm_stage_seq #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .EB_W(EB_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .dim_m_i(dim_m_i), .dim_n_i(dim_n_i), .dim_k_i(dim_k_i),
      .tile_m_i(tile_m_i), .tile_n_i(tile_n_i), .tile_k_i(tile_k_i),
      .base_a_i(base_a_i), .base_b_i(base_b_i), .base_c_i(base_c_i),
      .elem_bytes_i(elem_bytes_i), .pin_a_i(pin_a_i), .pin_b_i(pin_b_i),
      .busy_o(busy_o), .done_o(done_o), .cmd_valid_o(cmd_valid_o),
      .cmd_ready_i(cmd_ready_i), .cmd_kind_o(cmd_kind_o), .cmd_addr_o(cmd_addr_o),
      .cmd_bytes_o(cmd_bytes_o), .cmd_tag_o(cmd_tag_o), .cmd_dim0_o(cmd_dim0_o),
      .cmd_dim1_o(cmd_dim1_o), .cmd_first_o(cmd_first_o)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int ceil_cnt(input int d, input int t);
      int te = (t == 0) ? 1 : t;
      return (d == 0) ? 1 : (d + te - 1) / te;
   endfunction

   // behavioural model of the whole stream: R1, R2, R3, R4, R5, R6, R7, R11
   task automatic build(input int dm, input int dn, input int dk, input int tm,
                        input int tn, input int tk, input int eb, input longint ba,
                        input longint bb, input longint bc, input bit pa, input bit pb);
      int mt = ceil_cnt(dm, tm);
      int nt = ceil_cnt(dn, tn);
      int kt = ceil_cnt(dk, tk);
      longint sa = longint'(tm) * tk * eb;
      longint sb = longint'(tk) * tn * eb;
      longint sc = longint'(tm) * tn * eb;
      cmd_t c;
      exp_q.delete();
      for (int m = 0; m < mt; m++)
         for (int n = 0; n < nt; n++)
            for (int k = 0; k < kt; k++) begin
               if (!pa) begin
                  c = '{3'd1, ADDR_W'(ba + (longint'(m) * kt + k) * sa), BYTES_W'(sa),
                        2'd1, DIM_W'(tm), DIM_W'(tk), 1'b0};
                  exp_q.push_back(c);
               end
               if (!pb) begin
                  c = '{3'd1, ADDR_W'(bb + (longint'(k) * nt + n) * sb), BYTES_W'(sb),
                        2'd2, DIM_W'(tk), DIM_W'(tn), 1'b0};
                  exp_q.push_back(c);
               end
               c = '{3'd2, '0, BYTES_W'(sa + sb), 2'd0, DIM_W'(tm), DIM_W'(tn), 1'b0};
               exp_q.push_back(c);
               c = '{3'd3, '0, '0, 2'd0, DIM_W'(tm), DIM_W'(tn), (k == 0)};
               exp_q.push_back(c);
               if (k == kt - 1) begin
                  c = '{3'd4, ADDR_W'(bc + (longint'(m) * nt + n) * sc), BYTES_W'(sc),
                        2'd3, DIM_W'(tm), DIM_W'(tn), 1'b0};
                  exp_q.push_back(c);
                  c.kind = 3'd5;
                  exp_q.push_back(c);
               end
            end
   endtask

   task automatic run_case(input string name, input int dm, input int dn, input int dk,
                           input int tm, input int tn, input int tk, input int eb,
                           input longint ba, input longint bb, input longint bc,
                           input bit pa, input bit pb, input int rmode, input bit poke);
      int total;
      int taken = 0;
      int cyc = 0;
      cmd_t e;
      string tk_tag;
      build(dm, dn, dk, tm, tn, tk, eb, ba, bb, bc, pa, pb);
      total = exp_q.size();
      $display("case %s: %0d commands expected", name, total);
      @(negedge clk);
      dim_m_i = DIM_W'(dm); dim_n_i = DIM_W'(dn); dim_k_i = DIM_W'(dk);
      tile_m_i = DIM_W'(tm); tile_n_i = DIM_W'(tn); tile_k_i = DIM_W'(tk);
      elem_bytes_i = EB_W'(eb);
      base_a_i = ADDR_W'(ba); base_b_i = ADDR_W'(bb); base_c_i = ADDR_W'(bc);
      pin_a_i = pa; pin_b_i = pb;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (exp_q.size() > 0) begin
         e = exp_q[0];
         chk(cmd_valid_o === 1'b1, "R8", "valid while work remains", cmd_valid_o, 1);
         chk(done_o === 1'b0, "R9", "done before end", done_o, 0);
         tk_tag = (e.kind == 3'd1) ? "R4" : (e.kind >= 3'd4) ? "R5" : "R3";
         chk(cmd_kind_o === e.kind, tk_tag, "kind", cmd_kind_o, e.kind);
         // the address sequence follows the m, n, k walk order
         chk(cmd_addr_o === e.addr, "R2,R7", "addr", cmd_addr_o, e.addr);
         chk(cmd_bytes_o === e.bytes, "R6", "bytes", cmd_bytes_o, e.bytes);
         chk(cmd_tag_o === e.tag, "R6", "tag", cmd_tag_o, e.tag);
         chk(cmd_dim0_o === e.d0 && cmd_dim1_o === e.d1, "R6", "dims",
             {cmd_dim0_o, cmd_dim1_o}, {e.d0, e.d1});
         chk(cmd_first_o === e.first, "R11", "first flag", cmd_first_o, e.first);
         // R10: a second start with a different job while busy
         if (poke && cyc == 5) begin
            start_i = 1'b1;
            pin_a_i = ~pa; pin_b_i = ~pb;
            base_a_i = 32'h0BAD_0000; base_c_i = 32'h0DEF_0000;
            elem_bytes_i = EB_W'(1);
            dim_k_i = DIM_W'(1);
         end else begin
            start_i = 1'b0;
         end
         case (rmode)
            0: cmd_ready_i = 1'b1;
            1: cmd_ready_i = lfsr[0] | lfsr[3];
            default: cmd_ready_i = ((cyc % 4) == 3);
         endcase
         if (cmd_ready_i) begin
            void'(exp_q.pop_front());
            taken++;
         end
         @(negedge clk);
         cyc++;
      end
      start_i = 1'b0;
      cmd_ready_i = 1'b0;
      chk(done_o === 1'b1, "R9", "done after last write-back", done_o, 1);
      chk(busy_o === 1'b0, "R9", "busy low at done", busy_o, 0);
      chk(cmd_valid_o === 1'b0, "R9", "no command after end", cmd_valid_o, 0);
      chk(taken == total, poke ? "R10" : "R1", "command count", taken, total);
      @(negedge clk);
      chk(done_o === 1'b0, "R9", "done is one cycle", done_o, 0);
      chk(busy_o === 1'b0, "R10", "stays idle", busy_o, 0);
   endtask

   always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy_o === 1'b0, "R12", "busy in reset", busy_o, 0);
      chk(cmd_valid_o === 1'b0, "R12", "valid in reset", cmd_valid_o, 0);
      chk(done_o === 1'b0, "R12", "done in reset", done_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o === 1'b0 && cmd_valid_o === 1'b0, "R12", "idle after reset",
          {busy_o, cmd_valid_o}, 0);

      // ragged edges on all axes, nothing resident, random stalls (R1, R3)
      run_case("ragged", 5, 3, 7, 2, 2, 3, 2, 64'h1000, 64'h8000, 64'h2_0000,
               1'b0, 1'b0, 1, 1'b0);
      // zero dimensions, A resident, long stalls (R1, R4)
      run_case("pinA", 0, 0, 9, 3, 2, 4, 1, 64'h400, 64'h900, 64'hC00,
               1'b1, 1'b0, 2, 1'b0);
      // both resident, full throughput, zero tile size treated as one (R4)
      run_case("pinAB", 4, 6, 2, 2, 0, 1, 4, 64'h0, 64'h0, 64'h5000,
               1'b1, 1'b1, 0, 1'b0);
      // B resident with a start request in mid-job (R10)
      run_case("poke", 3, 4, 5, 2, 3, 2, 2, 64'hFFFF_FF00, 64'h7700, 64'h3300,
               1'b0, 1'b1, 1, 1'b1);
      // single inner step: store follows the first compute (R5, R11)
      run_case("onek", 2, 2, 3, 1, 1, 8, 8, 64'h100, 64'h200, 64'h300,
               1'b0, 1'b0, 0, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule